// File: doc/BRIEF.md
# Single-Precision Reciprocal Seed Unit

This unit takes a numerator and a denominator, both IEEE-754 single-precision words, and returns a starting estimate of one over the denominator. The estimate is good to roughly eight bits and is meant to feed a later Newton-Raphson division sequence. Along with the estimate it returns a small adjust code, the operands as the refinement should use them, and two exception flags (divide-by-zero and invalid).

A front end sorts every operand pair into one of five cases: NaN present, zero denominator, infinite denominator, subnormal denominator, or ordinary. Only the ordinary case reads the 128-entry seed table. The other cases rewrite the operands and force a fixed seed, so the refinement steps produce the right special result with no extra checks.

Operands enter through a valid/ready stream and leave through a second one, with one register stage between them. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output slot is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value.

Top module: `rcp_seed_unit`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An accepted operand pair shows up with `out_valid` high on the next clock. While the output is stalled, `out_valid` stays high and all outputs hold their values.
- R2: In the ordinary case the table index is denominator bits [22:16]. Entry i equals round(131072 / (257 + 2i)) - 256, except entry 127, which is 0. Spot values: entry 0 = 0xFE, entry 1 = 0xFA, entry 2 = 0xF6, entry 126 = 0x02, entry 127 = 0x00. Entries never increase as the index grows.
- R3: In the ordinary case the seed sign is denominator bit 31. Seed bits [22:15] hold the table entry, bits [14:1] are 0, and bit 0 is 1.
- R4: In the ordinary case the seed exponent field (bits [30:23]) is (253 - e_t) mod 256, where e_t is the denominator's exponent field. At e_t = 253 this gives 0, and at e_t = 254 it wraps to 255.
- R5: In the ordinary case both operands pass through unchanged and both flags are 0. The adjust code has bit 0 set when e_t >= 253, bit 1 set when the numerator's exponent field is 0, and all other bits clear.
- R6: For a zero denominator (any sign), the numerator output becomes infinity (0x7F800000 magnitude) with sign equal to the XOR of the two input signs. The denominator output and the seed become 1.0 (0x3F800000), and the adjust code is 0.
- R7: The divide-by-zero flag is 1 only for a zero denominator whose original numerator was not infinite. It is 0 in every other case.
- R8: For an infinite denominator, the numerator output becomes zero with sign equal to the XOR of the two input signs. The denominator output and the seed become 1.0. Both flags and the adjust code are 0.
- R9: If either operand is a NaN (exponent 0xFF, nonzero fraction), this case takes priority over R6, R8 and R10. The seed is 0x7FFFFFFF, both operands pass through unchanged, and the adjust code and divide-by-zero flag are 0. The invalid flag is 1 when either operand is a signaling NaN (fraction bit 22 = 0).
- R10: For a subnormal denominator (exponent 0, nonzero fraction), the seed is 1.0 and both operands pass through unchanged. The adjust code is 0x80 and both flags are 0.
- R11: In the ordinary case, the seed significand times the denominator significand, divided by 2, lies within 2^-7 of 1. This is the relative error of the seed with the exponents taken out.
- R12: While reset is asserted, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit can accept an operand pair |
| in_num | input | 32 | Numerator, single precision |
| in_den | input | 32 | Denominator, single precision |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_seed | output | 32 | Reciprocal estimate |
| out_adj | output | 8 | Adjust code |
| out_num | output | 32 | Numerator as rewritten |
| out_den | output | 32 | Denominator as rewritten |
| out_dz | output | 1 | Divide-by-zero flag |
| out_inv | output | 1 | Invalid flag (signaling NaN seen) |

## Verification
The bench builds the unit with its default parameters: the registered stage, a 7-bit index and an 8-bit entry. This exposes the handshake under random stalls on both sides and the full 128-entry table. A sweep drives every index once, so every table entry is compared against the rounding formula. Directed operands cover each case-priority corner, including both exponent extremes and a NaN paired with a zero denominator. The combinational build variant is not exercised.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
  parameter int unsigned FP_W   = 32;
  parameter int unsigned EXP_W  = 8;
  parameter int unsigned FRAC_W = 23;
  parameter int unsigned IDX_W  = 7;
  parameter int unsigned ENT_W  = 8;
  parameter int unsigned ADJ_W  = 8;

  localparam int unsigned BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int unsigned REFL   = 2 * BIAS - 1;
  localparam int unsigned DEPTH  = 1 << IDX_W;

  localparam logic [FP_W-1:0]  FP_ONE  = FP_W'(BIAS) << FRAC_W;
  localparam logic [FP_W-1:0]  FP_QNAN = {1'b0, {(FP_W-1){1'b1}}};
  localparam logic [FP_W-2:0]  FP_INF  = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [ADJ_W-1:0] ADJ_SUB = ADJ_W'(1) << (ADJ_W - 1);

  typedef struct packed {
    logic [FP_W-1:0]  seed;
    logic [ADJ_W-1:0] adj;
    logic [FP_W-1:0]  num;
    logic [FP_W-1:0]  den;
    logic             dz;
    logic             inv;
  } rcp_res_t;

  // Table entry k: fraction of 2/(1+(k+0.5)/2^idx_w), rounded to ent_w bits.
  function automatic int unsigned rcp_entry(int unsigned k, int unsigned idx_w,
                                            int unsigned ent_w);
    int unsigned d;
    int unsigned scale;
    int unsigned r;
    if (k == (1 << idx_w) - 1) return 0;
    d     = (2 << idx_w) + 1 + 2 * k;
    scale = 1 << (2 * ent_w + 1);
    r     = (2 * scale + d) / (2 * d);
    return r - (1 << ent_w);
  endfunction
endpackage

// File: rtl/rcp_classify.sv
module rcp_classify #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W-1:0] mag,
  output logic                    is_zero,
  output logic                    is_sub,
  output logic                    is_inf,
  output logic                    is_nan,
  output logic                    is_snan
);
  logic exp_ones, exp_none, frac_none;

  always_comb begin
    exp_ones  = &mag[EXP_W+FRAC_W-1:FRAC_W];
    exp_none  = ~|mag[EXP_W+FRAC_W-1:FRAC_W];
    frac_none = ~|mag[FRAC_W-1:0];
    is_zero   = exp_none & frac_none;
    is_sub    = exp_none & ~frac_none;
    is_inf    = exp_ones & frac_none;
    is_nan    = exp_ones & ~frac_none;
    is_snan   = is_nan & ~mag[FRAC_W-1];
  end
endmodule

// File: rtl/rcp_seed_rom.sv
module rcp_seed_rom
  import rcp_pkg::*;
#(
  parameter int unsigned ROM_IDX_W = IDX_W,
  parameter int unsigned ROM_ENT_W = ENT_W
) (
  input  logic [ROM_IDX_W-1:0] idx,
  output logic [ROM_ENT_W-1:0] entry
);
  localparam int unsigned ROM_DEPTH = 1 << ROM_IDX_W;

  logic [ROM_ENT_W-1:0] rom [ROM_DEPTH];

  for (genvar k = 0; k < ROM_DEPTH; k++) begin : g_ent
    assign rom[k] = ROM_ENT_W'(rcp_entry(k, ROM_IDX_W, ROM_ENT_W));
  end

  assign entry = rom[idx];
endmodule

// File: rtl/rcp_front.sv
module rcp_front
  import rcp_pkg::*;
(
  input  logic [FP_W-1:0] num,
  input  logic [FP_W-1:0] den,
  output rcp_res_t        res
);
  localparam int unsigned PAD_W = FRAC_W - ENT_W - 1;

  logic n_zero, n_sub, n_inf, n_nan, n_snan;
  logic d_zero, d_sub, d_inf, d_nan, d_snan;
  logic [ENT_W-1:0] tbl;
  logic [EXP_W-1:0] den_exp, seed_exp;
  logic             x_sign, den_hi, num_tiny;

  rcp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_num (
    .mag(num[FP_W-2:0]), .is_zero(n_zero), .is_sub(n_sub),
    .is_inf(n_inf), .is_nan(n_nan), .is_snan(n_snan)
  );

  rcp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_den (
    .mag(den[FP_W-2:0]), .is_zero(d_zero), .is_sub(d_sub),
    .is_inf(d_inf), .is_nan(d_nan), .is_snan(d_snan)
  );

  rcp_seed_rom u_rom (
    .idx(den[FRAC_W-1 -: IDX_W]),
    .entry(tbl)
  );

  always_comb begin
    den_exp  = den[FP_W-2:FRAC_W];
    seed_exp = EXP_W'(int'(REFL) - int'(den_exp));
    den_hi   = den_exp >= EXP_W'(REFL);
    num_tiny = n_zero | n_sub;
    x_sign   = num[FP_W-1] ^ den[FP_W-1];

    res.num  = num;
    res.den  = den;
    res.dz   = 1'b0;
    res.inv  = 1'b0;
    res.adj  = '0;
    res.seed = FP_ONE;

    if (n_nan | d_nan) begin
      res.seed = FP_QNAN;
      res.inv  = n_snan | d_snan;
    end else if (d_zero) begin
      res.num  = {x_sign, FP_INF};
      res.den  = FP_ONE;
      res.dz   = ~n_inf;
    end else if (d_inf) begin
      res.num  = {x_sign, {(FP_W-1){1'b0}}};
      res.den  = FP_ONE;
    end else if (d_sub) begin
      res.adj  = ADJ_SUB;
    end else begin
      res.seed = {den[FP_W-1], seed_exp, tbl, {PAD_W{1'b0}}, 1'b1};
      res.adj  = ADJ_W'({num_tiny, den_hi});
    end
  end
endmodule

// File: rtl/rcp_seed_unit.sv
module rcp_seed_unit
  import rcp_pkg::*;
#(
  parameter int unsigned REGISTERED = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FP_W-1:0]  in_num,
  input  logic [FP_W-1:0]  in_den,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [FP_W-1:0]  out_seed,
  output logic [ADJ_W-1:0] out_adj,
  output logic [FP_W-1:0]  out_num,
  output logic [FP_W-1:0]  out_den,
  output logic             out_dz,
  output logic             out_inv
);
  rcp_res_t comb_res, out_res;

  rcp_front u_front (
    .num(in_num),
    .den(in_den),
    .res(comb_res)
  );

  if (REGISTERED != 0) begin : g_reg
    logic     vld_q;
    rcp_res_t res_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) res_q <= comb_res;
      end
    end

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_res   = res_q;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_seed) && $stable(out_num)
                                  && $stable(out_den) && $stable(out_adj)); // R1
    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid); // R1
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_res   = comb_res;
  end

  assign out_seed = out_res.seed;
  assign out_adj  = out_res.adj;
  assign out_num  = out_res.num;
  assign out_den  = out_res.den;
  assign out_dz   = out_res.dz;
  assign out_inv  = out_res.inv;

  AST_DZ_FORCED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dz |-> out_seed == FP_ONE && out_den == FP_ONE
                            && out_adj == '0 && !out_inv); // R7
  AST_INV_GIVES_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_inv |-> out_seed == FP_QNAN && !out_dz && out_adj == '0); // R9
  AST_SUB_ADJ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_adj == ADJ_SUB |-> out_seed == FP_ONE && !out_dz && !out_inv); // R10
endmodule

// File: tb/tb_rcp_seed_unit.sv
`timescale 1ns/1ps
module tb_rcp_seed_unit;
  typedef struct packed {
    logic [31:0] seed;
    logic [7:0]  adj;
    logic [31:0] num;
    logic [31:0] den;
    logic        dz;
    logic        inv;
    logic        ordinary;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b0;
  logic [31:0] in_num = '0, in_den = '0;
  logic        in_ready, out_valid, out_dz, out_inv;
  logic [31:0] out_seed, out_num, out_den;
  logic [7:0]  out_adj;

  int errors = 0;
  int checks = 0;
  logic [31:0] stim_num[$];
  logic [31:0] stim_den[$];
  exp_t        exp_q[$];
  logic [31:0] rng = 32'h1234_5678;

  always #2 clk = ~clk;

  rcp_seed_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_num(in_num), .in_den(in_den), .out_valid(out_valid), .out_ready(out_ready),
    .out_seed(out_seed), .out_adj(out_adj), .out_num(out_num), .out_den(out_den),
    .out_dz(out_dz), .out_inv(out_inv)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic int tbl_val(input int i);
    if (i == 127) return 0;
    return $rtoi(131072.0 / (257.0 + 2.0 * i) + 0.5) - 256;
  endfunction

  function automatic exp_t model(input logic [31:0] n, input logic [31:0] d);
    exp_t e;
    int   en = int'(n[30:23]);
    int   ed = int'(d[30:23]);
    bit   nan_n = (en == 255) && (n[22:0] != 0);
    bit   nan_d = (ed == 255) && (d[22:0] != 0);
    bit   sx = n[31] ^ d[31];
    e = '0;
    e.num = n;
    e.den = d;
    e.seed = 32'h3F80_0000;
    if (nan_n || nan_d) begin
      e.seed = 32'h7FFF_FFFF;
      e.inv  = (nan_n && !n[22]) || (nan_d && !d[22]);
    end else if (ed == 0 && d[22:0] == 0) begin
      e.num = {sx, 31'h7F80_0000};
      e.den = 32'h3F80_0000;
      e.dz  = (en != 255);
    end else if (ed == 255) begin
      e.num = {sx, 31'h0};
      e.den = 32'h3F80_0000;
    end else if (ed == 0) begin
      e.adj = 8'h80;
    end else begin
      e.ordinary = 1'b1;
      e.seed = {d[31], 8'((253 - ed) & 255), 8'(tbl_val(int'(d[22:16]))), 14'h0, 1'b1};
      e.adj  = {6'h0, en == 0, ed >= 253};
    end
    return e;
  endfunction

  task automatic add(input logic [31:0] n, input logic [31:0] d);
    stim_num.push_back(n);
    stim_den.push_back(d);
  endtask

  task automatic compare(input exp_t e);
    real mt, ms, prod;
    int  idx;
    chk(out_seed == e.seed, e.ordinary ? "R3 R4 seed" : "R6 R8 R9 R10 seed", out_seed, e.seed);
    chk(out_num == e.num, "R5 R6 R8 num", out_num, e.num);
    chk(out_den == e.den, "R5 R6 R8 den", out_den, e.den);
    chk(out_adj == e.adj, "R5 R10 adj", 32'(out_adj), 32'(e.adj));
    chk(out_dz == e.dz, "R7 dz", 32'(out_dz), 32'(e.dz));
    chk(out_inv == e.inv, "R9 inv", 32'(out_inv), 32'(e.inv));
    if (e.ordinary) begin
      idx = int'(out_den[22:16]);
      // R2 spot values of the table
      if (idx == 0)   chk(out_seed[22:15] == 8'hFE, "R2 entry0",   32'(out_seed[22:15]), 32'hFE);
      if (idx == 1)   chk(out_seed[22:15] == 8'hFA, "R2 entry1",   32'(out_seed[22:15]), 32'hFA);
      if (idx == 2)   chk(out_seed[22:15] == 8'hF6, "R2 entry2",   32'(out_seed[22:15]), 32'hF6);
      if (idx == 126) chk(out_seed[22:15] == 8'h02, "R2 entry126", 32'(out_seed[22:15]), 32'h02);
      if (idx == 127) chk(out_seed[22:15] == 8'h00, "R2 entry127", 32'(out_seed[22:15]), 32'h00);
      mt   = 1.0 + real'(out_den[22:0]) / 8388608.0;
      ms   = 1.0 + real'(out_seed[22:0]) / 8388608.0;
      prod = ms * mt / 2.0;
      chk((prod - 1.0 < 0.0078125) && (1.0 - prod < 0.0078125), "R11 relerr",
          $rtoi(prod * 1.0e6), 32'd1000000);
    end
  endtask

  initial begin
    bit   stalled = 1'b0;
    logic [31:0] held = '0;
    int   sent = 0;
    int   rcvd = 0;
    int   cyc = 0;
    int   total;
    int   prev_tbl;
    exp_t e;

    // directed corners
    add(32'h3F80_0000, 32'h3F80_0000);   // 1/1
    add(32'h4000_0000, 32'h4040_0000);   // 3.0
    add(32'h3F80_0000, 32'hBF40_0000);   // -0.75
    add(32'h3F80_0000, 32'h0080_0000);   // e_t = 1
    add(32'h3F80_0000, 32'h7E80_0000);   // e_t = 253 -> exp 0
    add(32'h3F80_0000, 32'hFF7F_FFFF);   // e_t = 254 -> wrap
    add(32'h0000_0001, 32'h4000_0000);   // tiny numerator
    add(32'h3F80_0000, 32'h0000_0000);   // x/+0
    add(32'hC000_0000, 32'h8000_0000);   // -x/-0
    add(32'h3F80_0000, 32'h8000_0000);   // +x/-0
    add(32'h7F80_0000, 32'h0000_0000);   // inf/0, no dz
    add(32'h0000_0000, 32'h0000_0000);   // 0/0
    add(32'hBF80_0000, 32'h7F80_0000);   // -x/+inf
    add(32'h7F80_0000, 32'hFF80_0000);   // inf/-inf
    add(32'h7FC0_0000, 32'h3F80_0000);   // qnan num
    add(32'h7F80_0001, 32'h3F80_0000);   // snan num
    add(32'h3F80_0000, 32'hFF80_0001);   // snan den
    add(32'h7FC0_0000, 32'h0000_0000);   // nan beats zero den
    add(32'h3F80_0000, 32'h7FC0_0000);   // qnan den
    add(32'h3F80_0000, 32'h0000_1234);   // subnormal den
    add(32'h3F80_0000, 32'h807F_FFFF);   // -subnormal den
    for (int i = 0; i < 128; i++) add(32'h3FC0_0000, {1'b0, 8'd127, 7'(i), 16'h5A5A});
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      rng = next_rng(rng); a = rng;
      rng = next_rng(rng); b = rng;
      if (b[30:23] == 8'h00 || b[30:23] == 8'hFF) b[30:23] = 8'h80;
      if (i % 10 == 0) b[30:23] = 8'(i % 256);
      add(a, b);
    end
    total = stim_num.size();

    // R2 monotone table
    prev_tbl = 256;
    for (int i = 0; i < 128; i++) begin
      chk(tbl_val(i) <= prev_tbl, "R2 monotone", tbl_val(i), prev_tbl);
      prev_tbl = tbl_val(i);
    end

    // R12 reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R12 out_valid in reset", 32'(out_valid), 0);
      chk(in_ready == 1'b1, "R12 in_ready in reset", 32'(in_ready), 1);
    end
    rst_n = 1'b1;

    while (rcvd < total) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        chk(1'b0, "R1 watchdog", 32'(rcvd), 32'(total));
        break;
      end
      rng = next_rng(rng);
      in_valid  = (sent < total) && (rng[0] | rng[3]);
      if (sent < total) begin
        in_num = stim_num[sent];
        in_den = stim_den[sent];
      end
      out_ready = (cyc > 40 && cyc < 60) ? 1'b0 : (rng[1] | rng[5]);
      #1;
      chk(in_ready == (!out_valid || out_ready), "R1 ready rule", 32'(in_ready),
          32'(!out_valid || out_ready));
      if (stalled) begin
        chk(out_valid == 1'b1, "R1 valid held", 32'(out_valid), 1);
        chk(out_seed == held, "R1 seed held", out_seed, held);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 spurious output", 32'(out_valid), 0);
        end else begin
          e = exp_q.pop_front();
          compare(e);
          rcvd++;
        end
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(model(in_num, in_den));
        sent++;
      end
      stalled = out_valid && !out_ready;
      held    = out_seed;
    end
    in_valid = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule